// File: doc/BRIEF.md
# Load Alignment and Merge Unit

This block sits on the load return path of a 32-bit big-endian core, between data memory and the register file. Each transfer carries the aligned memory word, the low address bits of the effective address, the 6-bit load opcode, the current contents of the destination register and its index. The block produces the value to write back. It handles three load shapes. Byte and halfword loads are extracted from a lane and then sign- or zero-extended. Full-word loads pass through. The unaligned left and right partial loads splice shifted memory bytes into the old register contents.

Both sides use a valid/ready handshake. A transfer is accepted when `in_valid` and `in_ready` are both high on a rising edge. The result then sits in a single output register and is presented one cycle later with `out_valid` high. It stays there, unchanged, until `out_ready` is seen high. While the output register is full and the consumer stalls, `in_ready` is low, so upstream must hold its transfer. A full register that is drained in a cycle can take a new transfer in that same cycle, which gives full throughput.

Top module: `lam_unit`

## Requirements
- R1: Opcode 35 (word load) and opcode 48 (linked word load) both return the memory word unchanged.
- R2: Opcode 32 (signed byte) and opcode 36 (unsigned byte) select the byte lane big-endian: offset 0 selects bits [31:24] and offset 3 selects bits [7:0]. Opcode 32 sign-extends the byte and opcode 36 zero-extends it.
- R3: Opcode 33 (signed half) and opcode 37 (unsigned half) select bits [31:16] when offset bit 1 is 0 and bits [15:0] when it is 1; offset bit 0 is ignored. Opcode 33 sign-extends the half and opcode 37 zero-extends it.
- R4: Opcode 34 (left merge) at offset k returns the memory word shifted left by 8k bits, with the low 8k bits taken from the old register value. At offset 0 the whole register is replaced.
- R5: Opcode 38 (right merge) at offset k>0 returns the memory word shifted right by 8(4-k) bits, with the upper 8(4-k) bits taken from the old register value. At offset 0 it returns the old value unchanged.
- R6: When the destination index is 0, `out_wen` is low, whatever the opcode.
- R7: Any opcode other than the eight listed above gives `out_wen` low and `out_data` zero.
- R8: An accepted transfer appears on the outputs with `out_valid` high on the next clock edge, and results leave in the order they were accepted.
- R9: While `out_valid` is high and `out_ready` is low, `out_data`, `out_dst` and `out_wen` hold steady and `in_ready` is low. Otherwise `in_ready` is high.
- R10: During reset, and after it until the first transfer is accepted, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transfer offered |
| in_ready | output | 1 | Transfer can be taken this cycle |
| in_word | input | 32 | Aligned memory word |
| in_ofs | input | 2 | Low two bits of the effective address |
| in_op | input | 6 | Load opcode |
| in_old | input | 32 | Current destination register value |
| in_dst | input | 5 | Destination register index |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Value to write back |
| out_dst | output | 5 | Destination register index |
| out_wen | output | 1 | Write-back enable |

## Verification
The hardest case to reach from the ports is a stalled output register while a new transfer waits upstream. The stimulus has to check two things there: that the held result does not change, and that the waiting transfer is only taken in the very cycle the stall is released. The bench first runs a directed sweep of every opcode at every offset with patterns whose bytes are all distinct, so each lane choice can be told apart. It then runs a long random phase in which `in_valid` and `out_ready` toggle independently. Every clock is compared with a queue-based model, and that model never holds more than one result.

// File: rtl/lam_pkg.sv
package lam_pkg;
  localparam int OP_W = 6;

  typedef enum logic [OP_W-1:0] {
    OP_LDB  = 6'd32,
    OP_LDH  = 6'd33,
    OP_LDL  = 6'd34,
    OP_LDW  = 6'd35,
    OP_LDBU = 6'd36,
    OP_LDHU = 6'd37,
    OP_LDR  = 6'd38,
    OP_LDLK = 6'd48
  } ld_op_e;

  typedef enum logic [2:0] {
    SHP_NONE,
    SHP_BYTE,
    SHP_HALF,
    SHP_WORD,
    SHP_LEFT,
    SHP_RIGHT
  } ld_shape_e;

  typedef struct packed {
    ld_shape_e shape;
    logic      sext;
  } ld_ctl_t;

  function automatic ld_ctl_t decode_op(input logic [OP_W-1:0] op);
    ld_ctl_t c;
    c.shape = SHP_NONE;
    c.sext  = 1'b0;
    case (op)
      OP_LDB:          begin c.shape = SHP_BYTE; c.sext = 1'b1; end
      OP_LDBU:         c.shape = SHP_BYTE;
      OP_LDH:          begin c.shape = SHP_HALF; c.sext = 1'b1; end
      OP_LDHU:         c.shape = SHP_HALF;
      OP_LDW, OP_LDLK: c.shape = SHP_WORD;
      OP_LDL:          c.shape = SHP_LEFT;
      OP_LDR:          c.shape = SHP_RIGHT;
      default:         c.shape = SHP_NONE;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/lam_extract.sv
module lam_extract #(
  parameter int NB = 4,
  localparam int W  = 8 * NB,
  localparam int OW = $clog2(NB),
  localparam int NH = NB / 2
) (
  input  logic [W-1:0]  word,
  input  logic [OW-1:0] ofs,
  input  logic          half,
  input  logic          sext,
  output logic [W-1:0]  data
);
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  always_comb begin
    byte_sel = '0;
    for (int i = 0; i < NB; i++)
      if (ofs == OW'(NB - 1 - i)) byte_sel = word[i*8 +: 8];
  end

  always_comb begin
    half_sel = '0;
    for (int h = 0; h < NH; h++)
      if ((ofs >> 1) == OW'(NH - 1 - h)) half_sel = word[h*16 +: 16];
  end

  always_comb begin
    if (half)
      data = {{(W-16){sext & half_sel[15]}}, half_sel};
    else
      data = {{(W-8){sext & byte_sel[7]}}, byte_sel};
  end
endmodule

// File: rtl/lam_merge.sv
module lam_merge #(
  parameter int NB = 4,
  localparam int W  = 8 * NB,
  localparam int OW = $clog2(NB)
) (
  input  logic [W-1:0]  word,
  input  logic [W-1:0]  old,
  input  logic [OW-1:0] ofs,
  input  logic          left,
  output logic [W-1:0]  data
);
  // Lane j counts from the most significant byte (j = 0).
  for (genvar g = 0; g < NB; g++) begin : g_lane
    localparam int J = g;
    logic [7:0] lane;
    always_comb begin
      lane = old[(NB-1-J)*8 +: 8];
      for (int k = 0; k < NB; k++) begin
        if (ofs == OW'(k)) begin
          if (left) begin
            if (J + k < NB)
              lane = word[(NB-1-((J + k < NB) ? J + k : 0))*8 +: 8];
          end else begin
            if (J + k >= NB)
              lane = word[(NB-1-((J + k >= NB) ? J + k - NB : 0))*8 +: 8];
          end
        end
      end
    end
    assign data[(NB-1-J)*8 +: 8] = lane;
  end
endmodule

// File: rtl/lam_out_reg.sv
module lam_out_reg #(
  parameter int PW = 38
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_pay,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_pay
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pay   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_pay <= in_pay;
    end
  end
endmodule

// File: rtl/lam_unit.sv
module lam_unit
  import lam_pkg::*;
#(
  parameter int NB = 4,
  parameter int RW = 5,
  localparam int W  = 8 * NB,
  localparam int OW = $clog2(NB),
  localparam int PW = W + RW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [W-1:0]    in_word,
  input  logic [OW-1:0]   in_ofs,
  input  logic [OP_W-1:0] in_op,
  input  logic [W-1:0]    in_old,
  input  logic [RW-1:0]   in_dst,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_data,
  output logic [RW-1:0]   out_dst,
  output logic            out_wen
);
  ld_ctl_t    ctl;
  logic [W-1:0] ext_data, mrg_data;
  logic [W-1:0] res;
  logic       wen;

  assign ctl = decode_op(in_op);

  lam_extract #(.NB(NB)) u_ext (
    .word (in_word),
    .ofs  (in_ofs),
    .half (ctl.shape == SHP_HALF),
    .sext (ctl.sext),
    .data (ext_data)
  );

  lam_merge #(.NB(NB)) u_mrg (
    .word (in_word),
    .old  (in_old),
    .ofs  (in_ofs),
    .left (ctl.shape == SHP_LEFT),
    .data (mrg_data)
  );

  always_comb begin
    case (ctl.shape)
      SHP_BYTE, SHP_HALF:  res = ext_data;
      SHP_WORD:            res = in_word;
      SHP_LEFT, SHP_RIGHT: res = mrg_data;
      default:             res = '0;
    endcase
  end

  assign wen = (ctl.shape != SHP_NONE) && (in_dst != '0);

  lam_out_reg #(.PW(PW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_pay    ({res, in_dst, wen}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pay   ({out_data, out_dst, out_wen})
  );
endmodule

// File: rtl/lam_unit_chk.sv
module lam_unit_chk #(
  parameter int NB = 4,
  parameter int RW = 5,
  localparam int W  = 8 * NB,
  localparam int OW = $clog2(NB)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [W-1:0]  in_word,
  input logic [OW-1:0] in_ofs,
  input logic [5:0]    in_op,
  input logic [W-1:0]  in_old,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_data,
  input logic [RW-1:0] out_dst,
  input logic          out_wen
);
  wire acc = in_valid && in_ready;

  a_r10_reset_idle: assert property (@(posedge clk) !rst_n |=> !out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_dst) && $stable(out_wen));

  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r6_zero_dst: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dst == '0 |-> !out_wen);

  a_r1_word_pass: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == 6'd35 || in_op == 6'd48) |=> out_data == $past(in_word));

  a_r5_right_ofs0: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 6'd38 && in_ofs == '0 |=> out_data == $past(in_old));

  a_r2_zext_byte: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 6'd36 |=> out_data[W-1:8] == '0);
endmodule

bind lam_unit lam_unit_chk #(.NB(NB), .RW(RW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_word   (in_word),
  .in_ofs    (in_ofs),
  .in_op     (in_op),
  .in_old    (in_old),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_dst   (out_dst),
  .out_wen   (out_wen)
);

// File: tb/lam_unit_tb.sv
module lam_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [1:0]  in_ofs = '0;
  logic [5:0]  in_op = '0;
  logic [31:0] in_old = '0;
  logic [4:0]  in_dst = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic [4:0]  out_dst;
  logic        out_wen;

  int vectors = 0;
  int fails = 0;

  always #10ns clk = ~clk;

  lam_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_ofs(in_ofs), .in_op(in_op), .in_old(in_old),
    .in_dst(in_dst), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_dst(out_dst), .out_wen(out_wen)
  );

  typedef struct {
    logic [31:0] data;
    logic [4:0]  dst;
    logic        wen;
    string       tag;
  } exp_t;

  exp_t q[$];

  function automatic exp_t model(input logic [5:0] op, input logic [1:0] k,
                                 input logic [31:0] w, input logic [31:0] old,
                                 input logic [4:0] dst);
    exp_t e;
    logic [31:0] b;
    logic [15:0] h;
    logic known;
    known = 1'b1;
    e.data = '0;
    h = k[1] ? w[15:0] : w[31:16];
    b = w >> (8 * (3 - int'(k)));
    case (op)
      6'd32: begin e.data = {{24{b[7]}}, b[7:0]}; e.tag = "R2"; end
      6'd36: begin e.data = {24'h0, b[7:0]};      e.tag = "R2"; end
      6'd33: begin e.data = {{16{h[15]}}, h};     e.tag = "R3"; end
      6'd37: begin e.data = {16'h0, h};           e.tag = "R3"; end
      6'd35, 6'd48: begin e.data = w;             e.tag = "R1"; end
      6'd34: begin
        e.tag = "R4";
        case (k)
          2'd0: e.data = w;
          2'd1: e.data = (w << 8)  | (old & 32'h0000_00ff);
          2'd2: e.data = (w << 16) | (old & 32'h0000_ffff);
          default: e.data = (w << 24) | (old & 32'h00ff_ffff);
        endcase
      end
      6'd38: begin
        e.tag = "R5";
        case (k)
          2'd0: e.data = old;
          2'd1: e.data = (w >> 24) | (old & 32'hffff_ff00);
          2'd2: e.data = (w >> 16) | (old & 32'hffff_0000);
          default: e.data = (w >> 8) | (old & 32'hff00_0000);
        endcase
      end
      default: begin known = 1'b0; e.tag = "R7"; end
    endcase
    e.dst = dst;
    e.wen = known && (dst != 5'd0);
    if (dst == 5'd0) e.tag = {e.tag, "/R6"};
    return e;
  endfunction

  // reference model: one result slot, updated on every edge
  always @(posedge clk) begin
    if (!rst_n) q.delete();
    else begin
      bit rdy;
      rdy = (q.size() == 0) || out_ready;
      if (q.size() != 0 && out_ready) void'(q.pop_front());
      if (in_valid && rdy) q.push_back(model(in_op, in_ofs, in_word, in_old, in_dst));
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) chk("R10", "out_valid in reset", 32'(out_valid), 32'd0);
    else begin
      chk("R8", "out_valid", 32'(out_valid), 32'(q.size() != 0));
      chk("R9", "in_ready", 32'(in_ready), 32'((q.size() == 0) || out_ready));
      if (out_valid && q.size() != 0) begin
        chk(q[0].tag, "out_data", out_data, q[0].data);
        chk(q[0].tag, "out_wen", 32'(out_wen), 32'(q[0].wen));
        chk("R8", "out_dst", 32'(out_dst), 32'(q[0].dst));
      end
    end
  end

  task automatic drive(input logic v, input logic [5:0] op, input logic [1:0] k,
                       input logic [31:0] w, input logic [31:0] old,
                       input logic [4:0] dst, input logic rdy);
    @(negedge clk);
    #1ns;
    in_valid = v; in_op = op; in_ofs = k; in_word = w;
    in_old = old; in_dst = dst; out_ready = rdy;
  endtask

  initial begin
    logic [5:0] ops[8] = '{6'd32, 6'd33, 6'd34, 6'd35, 6'd36, 6'd37, 6'd38, 6'd48};
    repeat (3) @(negedge clk);
    #1ns rst_n = 1'b1;
    repeat (2) drive(0, 0, 0, 0, 0, 0, 1); // R10 idle after reset
    // directed sweep: every opcode, every offset, two patterns
    foreach (ops[i])
      for (int k = 0; k < 4; k++) begin
        drive(1, ops[i], 2'(k), 32'h8192_a3b4, 32'hc5d6_e7f8, 5'd7, 1);
        drive(1, ops[i], 2'(k), 32'h1122_7f44, 32'h5566_7788, 5'd31, 1);
      end
    // R6 zero destination, R7 non-load opcodes
    drive(1, 6'd35, 0, 32'hdead_beef, 32'h0, 5'd0, 1);
    drive(1, 6'd38, 2, 32'hdead_beef, 32'h1234_5678, 5'd0, 1);
    drive(1, 6'd43, 1, 32'hffff_ffff, 32'hffff_ffff, 5'd3, 1);
    drive(1, 6'd0,  3, 32'hffff_ffff, 32'hffff_ffff, 5'd4, 1);
    drive(1, 6'd63, 0, 32'h8080_8080, 32'h0, 5'd5, 1);
    // R9 stall with a waiting transfer
    drive(1, 6'd32, 0, 32'h80ff_ffff, 32'h0, 5'd9, 0);
    drive(1, 6'd37, 2, 32'h0000_9abc, 32'h0, 5'd10, 0);
    drive(1, 6'd37, 2, 32'h0000_9abc, 32'h0, 5'd10, 0);
    drive(1, 6'd37, 2, 32'h0000_9abc, 32'h0, 5'd10, 1);
    drive(0, 0, 0, 0, 0, 0, 1);
    // random phase
    for (int n = 0; n < 6000; n++) begin
      logic [5:0] op;
      op = ($urandom_range(0, 9) == 0) ? 6'($urandom) : ops[$urandom_range(0, 7)];
      drive($urandom_range(0, 3) != 0, op, 2'($urandom), $urandom, $urandom,
            5'($urandom), $urandom_range(0, 2) != 0);
    end
    drive(0, 0, 0, 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20ns * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule